// File: doc/BRIEF.md
# Pointer Data Address Generator

This block computes the effective address for a data-memory load or store. It holds three 16-bit pointer registers, numbered 0, 1 and 2. For each access request it returns the address and, for the auto-modifying modes, the updated pointer value. The addressing modes are plain indirect, indirect with post-increment, indirect with pre-decrement, indirect with an unsigned displacement, and unpaged direct. Pointer 0 is the reduced pointer: it has no displacement mode.

The decode stage sets the mode, the pointer selector and the displacement, then raises `start_i` for one cycle. An indirect request finishes one cycle later, with `done_o` high and the results on the outputs. The pointer register is already written back at that point. A direct request carries its 16-bit address in a second instruction word, so it needs one extra cycle. The unit samples `direct_word_i` in the cycle after the start and raises `done_o` a cycle after that. A separate load port writes a pointer while the unit is idle.

The controller has three states. `ST_IDLE` waits for a start. A start with an indirect mode moves it to `ST_DONE`. A start with direct mode moves it to `ST_WORD`. `ST_WORD` always moves to `ST_DONE`. `ST_DONE` always returns to `ST_IDLE`.

Top module: `pointer_agu`

## Requirements
- R1: After reset `done_o`, `ptr_we_o` and `illegal_o` are 0, and all three pointers read as 0x0000.
- R2: Plain mode (mode code 0) returns the selected pointer as the address with `ptr_we_o`=0. `done_o` is high for exactly one cycle, one cycle after the start.
- R3: Post-increment mode (code 1) returns the old pointer value as the address and writes back old+1. `ptr_we_o`=1, `ptr_new_o`=old+1 and `ptr_idx_o` equal to the selector.
- R4: Pre-decrement mode (code 2) writes back old−1 and returns that new value as the address.
- R5: Displacement mode (code 3) returns pointer + `disp_i` (unsigned, 0..63) and leaves the pointer unchanged.
- R6: Displacement mode on pointer 0 sets `illegal_o`=1 and `ptr_we_o`=0, and pointer 0 keeps its value.
- R7: Direct mode (code 4) returns `direct_word_i` as sampled one cycle after the start, in full and unpaged. `done_o` rises two cycles after the start and no pointer changes.
- R8: Pointer arithmetic wraps modulo 2^16: 0xFFFF+1=0x0000, 0x0000−1=0xFFFF, and 0xFFF0+63=0x002F.
- R9: A start raised while a request is in progress is ignored.
- R10: `ld_en_i` writes `ld_val_i` into pointer `ld_sel_i` when the unit is idle and no start is raised.
- R11: Selector value 3 with an indirect mode, or a mode code of 5 to 7, sets `illegal_o`=1 with `ptr_we_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe |
| mode_i | input | 3 | Addressing mode code |
| ptr_sel_i | input | 2 | Pointer selector |
| disp_i | input | 6 | Unsigned displacement |
| direct_word_i | input | 16 | Second instruction word holding the direct address |
| ld_en_i | input | 1 | Pointer load enable |
| ld_sel_i | input | 2 | Pointer to load |
| ld_val_i | input | 16 | Load value |
| ea_o | output | 16 | Effective address, valid while done_o is high |
| ptr_we_o | output | 1 | Pointer write-back occurred |
| ptr_idx_o | output | 2 | Pointer that was written back |
| ptr_new_o | output | 16 | New pointer value |
| illegal_o | output | 1 | Request was illegal |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong pointer value is invisible at the moment it is stored. It shows up on `ea_o` at the next request that reads that pointer, so every write-back is followed by a plain read of the same pointer. A wrong controller state shows at the ports within one or two cycles: `done_o` arrives at the wrong cycle, is missing, or lasts longer than one cycle. A direct address taken from the wrong cycle shows up because the direct word changes between the start cycle and the sampling cycle.

// File: rtl/agu_pkg.sv
package agu_pkg;
    typedef enum logic [2:0] {
        AM_PLAIN   = 3'd0,
        AM_POSTINC = 3'd1,
        AM_PREDEC  = 3'd2,
        AM_DISP    = 3'd3,
        AM_DIRECT  = 3'd4
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WORD = 2'd1,
        ST_DONE = 2'd2
    } agu_state_e;
endpackage

// File: rtl/agu_ptr_file.sv
module agu_ptr_file #(
    parameter int AW   = 16,
    parameter int NPTR = 3,
    parameter int SELW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SELW-1:0] rd_sel,
    output logic [AW-1:0]   rd_val,
    input  logic            wr_en,
    input  logic [SELW-1:0] wr_sel,
    input  logic [AW-1:0]   wr_val,
    input  logic            ld_en,
    input  logic [SELW-1:0] ld_sel,
    input  logic [AW-1:0]   ld_val
);
    logic [AW-1:0] ptr_q [NPTR];

    for (genvar i = 0; i < NPTR; i++) begin : g_ptr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ptr_q[i] <= '0;
            else if (wr_en && wr_sel == SELW'(i))
                ptr_q[i] <= wr_val;
            else if (ld_en && ld_sel == SELW'(i))
                ptr_q[i] <= ld_val;
        end
    end

    always_comb begin
        rd_val = '0;
        for (int k = 0; k < NPTR; k++)
            if (rd_sel == SELW'(k)) rd_val = ptr_q[k];
    end
endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
    import agu_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 6,
    parameter int NPTR        = 3,
    parameter int SELW        = 2,
    parameter int REDUCED_PTR = 0
) (
    input  amode_e          mode,
    input  logic [SELW-1:0] sel,
    input  logic [AW-1:0]   ptr,
    input  logic [DW-1:0]   disp,
    output logic [AW-1:0]   ea,
    output logic [AW-1:0]   new_val,
    output logic            we,
    output logic            illegal
);
    logic sel_ok;
    assign sel_ok = int'(sel) < NPTR;

    always_comb begin
        ea      = ptr;
        new_val = ptr;
        we      = 1'b0;
        illegal = 1'b0;
        case (mode)
            AM_PLAIN:   ea = ptr;
            AM_POSTINC: begin
                new_val = ptr + AW'(1);
                we      = 1'b1;
            end
            AM_PREDEC: begin
                new_val = ptr - AW'(1);
                ea      = new_val;
                we      = 1'b1;
            end
            AM_DISP: begin
                if (int'(sel) == REDUCED_PTR) illegal = 1'b1;
                else                          ea = ptr + AW'(disp);
            end
            AM_DIRECT:  ea = ptr;
            default:    illegal = 1'b1;
        endcase
        if (!sel_ok && mode != AM_DIRECT) illegal = 1'b1;
        if (illegal) begin
            we      = 1'b0;
            ea      = '0;
            new_val = ptr;
        end
    end
endmodule

// File: rtl/agu_ctrl.sv
module agu_ctrl
    import agu_pkg::*;
#(
    parameter int AW   = 16,
    parameter int SELW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  amode_e          mode,
    input  logic [SELW-1:0] sel,
    input  logic [AW-1:0]   direct_word,
    input  logic [AW-1:0]   calc_ea,
    input  logic [AW-1:0]   calc_new,
    input  logic            calc_we,
    input  logic            calc_illegal,
    output agu_state_e      state,
    output logic            wr_en,
    output logic [AW-1:0]   ea_q,
    output logic            we_q,
    output logic [SELW-1:0] idx_q,
    output logic [AW-1:0]   new_q,
    output logic            illegal_q,
    output logic            done_q
);
    agu_state_e state_nx;
    logic       accept;

    assign accept = (state == ST_IDLE) && start;
    assign wr_en  = accept && calc_we && (mode != AM_DIRECT);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = (mode == AM_DIRECT) ? ST_WORD : ST_DONE;
            ST_WORD: state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_q      <= '0;
            we_q      <= 1'b0;
            idx_q     <= '0;
            new_q     <= '0;
            illegal_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept && mode != AM_DIRECT) begin
                        ea_q      <= calc_ea;
                        new_q     <= calc_new;
                        we_q      <= calc_we;
                        illegal_q <= calc_illegal;
                        idx_q     <= sel;
                        done_q    <= 1'b1;
                    end
                end
                ST_WORD: begin
                    ea_q      <= direct_word;
                    new_q     <= '0;
                    we_q      <= 1'b0;
                    illegal_q <= 1'b0;
                    done_q    <= 1'b1;
                end
                ST_DONE: begin
                    we_q      <= 1'b0;
                    illegal_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pointer_agu.sv
module pointer_agu
    import agu_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 6,
    parameter int NPTR        = 3,
    parameter int REDUCED_PTR = 0,
    localparam int SELW       = (NPTR > 2) ? $clog2(NPTR) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [2:0]      mode_i,
    input  logic [SELW-1:0] ptr_sel_i,
    input  logic [DW-1:0]   disp_i,
    input  logic [AW-1:0]   direct_word_i,
    input  logic            ld_en_i,
    input  logic [SELW-1:0] ld_sel_i,
    input  logic [AW-1:0]   ld_val_i,
    output logic [AW-1:0]   ea_o,
    output logic            ptr_we_o,
    output logic [SELW-1:0] ptr_idx_o,
    output logic [AW-1:0]   ptr_new_o,
    output logic            illegal_o,
    output logic            done_o
);
    amode_e     mode;
    agu_state_e state;
    logic [AW-1:0] rd_val, c_ea, c_new;
    logic          c_we, c_ill, wr_en, ld_ok;

    assign mode  = amode_e'(mode_i);
    assign ld_ok = ld_en_i && (state == ST_IDLE) && !start_i;

    agu_ptr_file #(.AW(AW), .NPTR(NPTR), .SELW(SELW)) u_ptrs (
        .clk(clk), .rst_n(rst_n),
        .rd_sel(ptr_sel_i), .rd_val(rd_val),
        .wr_en(wr_en), .wr_sel(ptr_sel_i), .wr_val(c_new),
        .ld_en(ld_ok), .ld_sel(ld_sel_i), .ld_val(ld_val_i)
    );

    agu_addr_calc #(.AW(AW), .DW(DW), .NPTR(NPTR), .SELW(SELW),
                    .REDUCED_PTR(REDUCED_PTR)) u_calc (
        .mode(mode), .sel(ptr_sel_i), .ptr(rd_val), .disp(disp_i),
        .ea(c_ea), .new_val(c_new), .we(c_we), .illegal(c_ill)
    );

    agu_ctrl #(.AW(AW), .SELW(SELW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start_i), .mode(mode),
        .sel(ptr_sel_i), .direct_word(direct_word_i),
        .calc_ea(c_ea), .calc_new(c_new), .calc_we(c_we), .calc_illegal(c_ill),
        .state(state), .wr_en(wr_en),
        .ea_q(ea_o), .we_q(ptr_we_o), .idx_q(ptr_idx_o), .new_q(ptr_new_o),
        .illegal_q(illegal_o), .done_q(done_o)
    );
endmodule

// File: rtl/pointer_agu_sva.sv
module pointer_agu_sva
    import agu_pkg::*;
#(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [2:0]    mode_i,
    input agu_state_e    state,
    input logic [AW-1:0] ea_o,
    input logic [AW-1:0] ptr_new_o,
    input logic          ptr_we_o,
    input logic          illegal_o,
    input logic          done_o
);
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r2_indirect_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_i && mode_i != 3'd4) |=> done_o);

    a_r7_direct_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_i && mode_i == 3'd4) |=> !done_o);

    a_r7_direct_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_i && mode_i == 3'd4) |=> ##1 done_o);

    a_r6_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !ptr_we_o);

    a_r3_write_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we_o |-> done_o);

    // R3 and R4: a write-back is one step away from the address or equal to it
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we_o |-> (ptr_new_o == ea_o + AW'(1) || ptr_new_o == ea_o));
endmodule

bind pointer_agu pointer_agu_sva #(.AW(AW)) u_sva (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .state(state), .ea_o(ea_o), .ptr_new_o(ptr_new_o), .ptr_we_o(ptr_we_o),
    .illegal_o(illegal_o), .done_o(done_o)
);

// File: tb/pointer_agu_tb.sv
module pointer_agu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  mode_i = 3'd0;
    logic [1:0]  ptr_sel_i = 2'd0;
    logic [5:0]  disp_i = 6'd0;
    logic [15:0] direct_word_i = 16'd0;
    logic        ld_en_i = 1'b0;
    logic [1:0]  ld_sel_i = 2'd0;
    logic [15:0] ld_val_i = 16'd0;
    logic [15:0] ea_o, ptr_new_o;
    logic [1:0]  ptr_idx_o;
    logic        ptr_we_o, illegal_o, done_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pointer_agu u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .ptr_sel_i(ptr_sel_i), .disp_i(disp_i), .direct_word_i(direct_word_i),
        .ld_en_i(ld_en_i), .ld_sel_i(ld_sel_i), .ld_val_i(ld_val_i),
        .ea_o(ea_o), .ptr_we_o(ptr_we_o), .ptr_idx_o(ptr_idx_o),
        .ptr_new_o(ptr_new_o), .illegal_o(illegal_o), .done_o(done_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [1:0] s, input logic [15:0] v);
        @(negedge clk);
        ld_en_i = 1'b1; ld_sel_i = s; ld_val_i = v;
        @(negedge clk);
        ld_en_i = 1'b0;
    endtask

    // Issues one request; returns at the negedge where done_o should be high
    task automatic op(input logic [2:0] m, input logic [1:0] s,
                      input logic [5:0] d, input logic [15:0] w);
        @(negedge clk);
        start_i = 1'b1; mode_i = m; ptr_sel_i = s; disp_i = d;
        direct_word_i = ~w;
        @(negedge clk);
        start_i = 1'b0;
        if (m == 3'd4) begin
            chk("R7 done not yet", done_o, 0);
            direct_word_i = w;
            @(negedge clk);
        end
        chk("R2/R7 done", done_o, 1);
    endtask

    task automatic read_ptr(input string req, input logic [1:0] s, input logic [15:0] exp);
        op(3'd0, s, 6'd0, 16'd0);
        chk(req, ea_o, exp);
        chk(req, ptr_we_o, 0);
    endtask

    task automatic t_reset;
        chk("R1 done", done_o, 0);
        chk("R1 we", ptr_we_o, 0);
        chk("R1 illegal", illegal_o, 0);
        for (int i = 0; i < 3; i++) read_ptr("R1 pointer zero", 2'(i), 16'h0000);
    endtask

    task automatic t_load_plain;
        load(2'd0, 16'h0100);
        load(2'd1, 16'h1234);
        load(2'd2, 16'hFFFF);
        read_ptr("R10 load P0", 2'd0, 16'h0100);
        read_ptr("R2 plain P1", 2'd1, 16'h1234);
        @(negedge clk);
        chk("R2 done single cycle", done_o, 0);
        read_ptr("R10 load P2", 2'd2, 16'hFFFF);
    endtask

    task automatic t_postinc;
        op(3'd1, 2'd1, 6'd0, 16'd0);
        chk("R3 ea", ea_o, 16'h1234);
        chk("R3 we", ptr_we_o, 1);
        chk("R3 new", ptr_new_o, 16'h1235);
        chk("R3 idx", ptr_idx_o, 2'd1);
        read_ptr("R3 readback", 2'd1, 16'h1235);
    endtask

    task automatic t_predec;
        op(3'd2, 2'd0, 6'd0, 16'd0);
        chk("R4 ea", ea_o, 16'h00FF);
        chk("R4 new", ptr_new_o, 16'h00FF);
        chk("R4 we", ptr_we_o, 1);
        read_ptr("R4 readback", 2'd0, 16'h00FF);
    endtask

    task automatic t_disp;
        op(3'd3, 2'd1, 6'd63, 16'd0);
        chk("R5 disp 63", ea_o, 16'h1274);
        chk("R5 no write", ptr_we_o, 0);
        op(3'd3, 2'd2, 6'd0, 16'd0);
        chk("R5 disp 0", ea_o, 16'hFFFF);
        read_ptr("R5 unchanged", 2'd1, 16'h1235);
    endtask

    task automatic t_reduced;
        op(3'd3, 2'd0, 6'd5, 16'd0);
        chk("R6 illegal", illegal_o, 1);
        chk("R6 no write", ptr_we_o, 0);
        read_ptr("R6 P0 kept", 2'd0, 16'h00FF);
        chk("R6 illegal cleared", illegal_o, 0);
    endtask

    task automatic t_direct;
        op(3'd4, 2'd1, 6'd0, 16'hBEEF);
        chk("R7 ea", ea_o, 16'hBEEF);
        chk("R7 no write", ptr_we_o, 0);
        chk("R7 legal", illegal_o, 0);
        read_ptr("R7 P1 kept", 2'd1, 16'h1235);
    endtask

    task automatic t_wrap;
        op(3'd1, 2'd2, 6'd0, 16'd0);
        chk("R8 inc ea", ea_o, 16'hFFFF);
        chk("R8 inc wrap", ptr_new_o, 16'h0000);
        op(3'd2, 2'd2, 6'd0, 16'd0);
        chk("R8 dec wrap", ptr_new_o, 16'hFFFF);
        chk("R8 dec ea", ea_o, 16'hFFFF);
        load(2'd1, 16'hFFF0);
        op(3'd3, 2'd1, 6'd63, 16'd0);
        chk("R8 disp wrap", ea_o, 16'h002F);
    endtask

    task automatic t_busy;
        @(negedge clk);
        start_i = 1'b1; mode_i = 3'd4; direct_word_i = 16'h0042;
        @(negedge clk);
        mode_i = 3'd1; ptr_sel_i = 2'd1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R9 direct completes", done_o, 1);
        chk("R9 ea from word", ea_o, 16'h0042);
        chk("R9 no write", ptr_we_o, 0);
        read_ptr("R9 P1 untouched", 2'd1, 16'hFFF0);
    endtask

    task automatic t_illegal_codes;
        op(3'd1, 2'd3, 6'd0, 16'd0);
        chk("R11 sel 3", illegal_o, 1);
        chk("R11 sel 3 no write", ptr_we_o, 0);
        op(3'd6, 2'd1, 6'd0, 16'd0);
        chk("R11 mode 6", illegal_o, 1);
        chk("R11 mode 6 no write", ptr_we_o, 0);
        read_ptr("R11 P1 untouched", 2'd1, 16'hFFF0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected < 20000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_plain();
        t_postinc();
        t_predec();
        t_disp();
        t_reduced();
        t_direct();
        t_wrap();
        t_busy();
        t_illegal_codes();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule